// File: doc/BRIEF.md
# DDR input capture with same-edge realignment

This block turns a double-data-rate serial input into two parallel bits per lane that reach downstream logic on a single clock edge. One register per lane samples the input on the rising edge of the lead clock. A second register samples it on the rising edge of the trail clock, which is normally the inverse of the lead clock. Without further work, the trail sample would have to be moved into the lead clock domain by fabric logic. That transfer has only half a period of timing budget at a 50% duty cycle.

In realign mode, both samples pass through one more register stage clocked by the rising lead edge. A bit taken on a lead edge and the bit taken on the trail edge that follows it then appear together one lead edge later. Downstream logic needs only the lead clock. A bypass mode, chosen by parameter, drops that stage: the lead sample is presented directly and the trail register drives the late output on its own clock. Reset is synchronous and active high. A clock enable freezes every register. Lanes are independent copies of the same path.

Top module: `ddr_in_capture`

## Requirements
- R1: On each rising edge of `clk_lead` with `ce` high and `rst` low, the lead register takes `ser_in`. In bypass mode (`PATH` = `PATH_BYPASS`, value 0), `par_early` shows that value right after the edge.
- R2: On each rising edge of `clk_trail` with `ce` high and `rst` low, the trail register takes `ser_in`. In bypass mode, `par_late` shows that value until the next trail edge.
- R3: In realign mode (`PATH` = `PATH_REALIGN`, value 1), a bit sampled on a lead edge and the bit sampled on the trail edge after it appear together on `par_early` and `par_late` after the next lead edge. Both outputs change only on lead edges.
- R4: Bypass mode adds no stage. `par_early` is the lead register and `par_late` is the trail register, so the late output changes on trail edges.
- R5: While `rst` is high, each register clears to zero on its own clock edge. Reset takes priority over a low `ce`.
- R6: While `ce` is low, every register holds its value on its clock edges. The samples presented during that time never reach the outputs.
- R7: Bit i of `ser_in` feeds only bit i of `par_early` and `par_late`. There is no crossing between lanes.
- R8: After reset is released in realign mode, the outputs stay zero through the first lead edge. The first sampled pair appears after the following lead edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_lead | input | 1 | Lead capture clock; all realigned outputs change on its rising edge |
| clk_trail | input | 1 | Trail capture clock, normally the inverse of `clk_lead` |
| rst | input | 1 | Synchronous active-high reset for every register |
| ce | input | 1 | Clock enable; low holds every register |
| ser_in | input | LANES | Double-data-rate serial input, one bit per lane |
| par_early | output | LANES | Bit sampled on the lead edge |
| par_late | output | LANES | Bit sampled on the trail edge |

## Verification
On every lead edge, the assertions check that the realigned outputs equal the capture registers' values from the previous edge. They also check that a low enable freezes the registers in both clock domains and that a reset leaves the lead-domain outputs at zero. Only the bench's scenarios can show that the two outputs carry consecutive bits of the serial stream in the correct order. The same holds for the first pair after reset arriving exactly one lead edge after it was sampled, for samples skipped under a low enable never appearing, and for the lanes staying separate.

// File: rtl/ddr_cap_pkg.sv
package ddr_cap_pkg;
    typedef enum logic {
        PATH_BYPASS  = 1'b0,
        PATH_REALIGN = 1'b1
    } path_e;
endpackage

// File: rtl/ddr_cap_stage.sv
// One bank of capture registers on a single clock edge.
module ddr_cap_stage #(
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic [LANES-1:0] din,
    output logic [LANES-1:0] dout
);
    typedef struct packed {
        logic [LANES-1:0] smp;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d = '0;
        end else if (ce) begin
            st_d.smp = din;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign dout = st_q.smp;
endmodule

// File: rtl/ddr_cap_realign.sv
// Re-registers both capture samples on the lead clock so they leave as a pair.
module ddr_cap_realign #(
    parameter int LANES = 2
) (
    input  logic             clk_lead,
    input  logic             rst,
    input  logic             ce,
    input  logic [LANES-1:0] lead_in,
    input  logic [LANES-1:0] trail_in,
    output logic [LANES-1:0] early_out,
    output logic [LANES-1:0] late_out
);
    typedef struct packed {
        logic [LANES-1:0] early;
        logic [LANES-1:0] late;
    } pair_t;

    pair_t pr_d, pr_q;

    always_comb begin
        pr_d = pr_q;
        if (rst) begin
            pr_d = '0;
        end else if (ce) begin
            pr_d.early = lead_in;
            pr_d.late  = trail_in;
        end
    end

    always_ff @(posedge clk_lead) begin
        pr_q <= pr_d;
    end

    assign early_out = pr_q.early;
    assign late_out  = pr_q.late;
endmodule

// File: rtl/ddr_in_capture.sv
module ddr_in_capture #(
    parameter int                 LANES = 2,
    parameter ddr_cap_pkg::path_e PATH  = ddr_cap_pkg::PATH_REALIGN
) (
    input  logic             clk_lead,
    input  logic             clk_trail,
    input  logic             rst,
    input  logic             ce,
    input  logic [LANES-1:0] ser_in,
    output logic [LANES-1:0] par_early,
    output logic [LANES-1:0] par_late
);
    localparam bit REALIGN = (PATH == ddr_cap_pkg::PATH_REALIGN);

    logic [LANES-1:0] lead_s;
    logic [LANES-1:0] trail_s;

    ddr_cap_stage #(.LANES(LANES)) u_lead (
        .clk  (clk_lead),
        .rst  (rst),
        .ce   (ce),
        .din  (ser_in),
        .dout (lead_s)
    );

    ddr_cap_stage #(.LANES(LANES)) u_trail (
        .clk  (clk_trail),
        .rst  (rst),
        .ce   (ce),
        .din  (ser_in),
        .dout (trail_s)
    );

    generate
        if (REALIGN) begin : g_realign
            ddr_cap_realign #(.LANES(LANES)) u_align (
                .clk_lead  (clk_lead),
                .rst       (rst),
                .ce        (ce),
                .lead_in   (lead_s),
                .trail_in  (trail_s),
                .early_out (par_early),
                .late_out  (par_late)
            );
        end else begin : g_bypass
            assign par_early = lead_s;
            assign par_late  = trail_s;
        end
    endgenerate
endmodule

// File: rtl/ddr_in_capture_chk.sv
module ddr_in_capture_chk #(
    parameter int                 LANES = 2,
    parameter ddr_cap_pkg::path_e PATH  = ddr_cap_pkg::PATH_REALIGN
) (
    input logic             clk_lead,
    input logic             clk_trail,
    input logic             rst,
    input logic             ce,
    input logic [LANES-1:0] lead_s,
    input logic [LANES-1:0] trail_s,
    input logic [LANES-1:0] par_early,
    input logic [LANES-1:0] par_late
);
    localparam bit REALIGN = (PATH == ddr_cap_pkg::PATH_REALIGN);

    logic rst_seen_q = 1'b0;

    always_ff @(posedge clk_lead) begin
        rst_seen_q <= rst;
    end

    // R5: one lead edge under reset leaves the lead-domain outputs at zero
    always_ff @(posedge clk_lead) begin
        if (rst_seen_q) begin
            a_r5_lead_clear: assert (par_early == '0 && (!REALIGN || par_late == '0))
                else $error("reset did not clear lead-domain outputs");
        end
    end

    // R3: realigned early bit is the lead sample from the previous edge
    a_r3_early_pair: assert property (@(posedge clk_lead) disable iff (rst)
        (REALIGN && ce) |=> (par_early == $past(lead_s)));

    // R3: realigned late bit is the trail sample held at the previous lead edge
    a_r3_late_pair: assert property (@(posedge clk_lead) disable iff (rst)
        (REALIGN && ce) |=> (par_late == $past(trail_s)));

    // R6: enable low freezes the lead-domain state
    a_r6_hold_lead: assert property (@(posedge clk_lead) disable iff (rst)
        !ce |=> ($stable(lead_s) && $stable(par_early) && (!REALIGN || $stable(par_late))));

    // R6: enable low freezes the trail register
    a_r6_hold_trail: assert property (@(posedge clk_trail) disable iff (rst)
        !ce |=> $stable(trail_s));
endmodule

bind ddr_in_capture ddr_in_capture_chk #(.LANES(LANES), .PATH(PATH)) u_chk (
    .clk_lead  (clk_lead),
    .clk_trail (clk_trail),
    .rst       (rst),
    .ce        (ce),
    .lead_s    (lead_s),
    .trail_s   (trail_s),
    .par_early (par_early),
    .par_late  (par_late)
);

// File: tb/sim_ddr_in_capture.sv
`timescale 1ns/1ps
module sim_ddr_in_capture;
    localparam int L = 2;

    logic         clk_lead = 1'b0;
    logic         clk_trail;
    logic         rst = 1'b1;
    logic         ce  = 1'b1;
    logic [L-1:0] ser = '0;
    logic [L-1:0] u0_early, u0_late, u1_early, u1_late;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [L-1:0] last_a = '0, last_b = '0, pp_a = '0, pp_b = '0;

    always #2.5 clk_lead = ~clk_lead;
    assign clk_trail = ~clk_lead;

    ddr_in_capture #(.LANES(L), .PATH(ddr_cap_pkg::PATH_REALIGN)) u0 (
        .clk_lead (clk_lead), .clk_trail (clk_trail), .rst (rst), .ce (ce),
        .ser_in (ser), .par_early (u0_early), .par_late (u0_late)
    );

    ddr_in_capture #(.LANES(L), .PATH(ddr_cap_pkg::PATH_BYPASS)) u1 (
        .clk_lead (clk_lead), .clk_trail (clk_trail), .rst (rst), .ce (ce),
        .ser_in (ser), .par_early (u1_early), .par_late (u1_late)
    );

    task automatic check(input string tag, input logic [L-1:0] act, input logic [L-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b", tag, act, exp);
        end
    endtask

    // Drive a on the next lead edge and b on the trail edge after it.
    task automatic step(input logic [L-1:0] a, input logic [L-1:0] b, input bit chk);
        @(negedge clk_lead); #1;
        ser = a;
        ce  = 1'b1;
        @(posedge clk_lead); #1;
        if (chk) begin
            check("R3 realigned early", u0_early, last_a);
            check("R3 realigned late", u0_late, last_b);
            check("R1 bypass early", u1_early, a);
            check("R2/R4 bypass late", u1_late, last_b);
        end
        ser  = b;
        pp_a = last_a; pp_b = last_b;
        last_a = a; last_b = b;
    endtask

    task automatic do_reset(input logic ce_val);
        @(negedge clk_lead); #1;
        rst = 1'b1;
        ce  = ce_val;
        ser = '1;
        repeat (2) @(posedge clk_lead);
        #1;
        check("R5 reset early", u0_early, '0);
        check("R5 reset late", u0_late, '0);
        check("R5 reset bypass early", u1_early, '0);
        check("R5 reset bypass late", u1_late, '0);
        @(negedge clk_lead); #1;
        rst = 1'b0;
        ce  = 1'b1;
        ser = '0;
        @(posedge clk_lead); #1;
        check("R8 zero after release early", u0_early, '0);
        check("R8 zero after release late", u0_late, '0);
        last_a = '0; last_b = '0; pp_a = '0; pp_b = '0;
    endtask

    function automatic logic [L-1:0] pat(input int i);
        logic [7:0] v;
        v = 8'((i * 5 + 3) ^ (i >> 1));
        return v[L-1:0];
    endfunction

    task automatic t_stream();
        for (int i = 0; i < 24; i++) begin
            step(pat(2 * i), pat(2 * i + 1), 1'b1);
        end
        // alternating and constant patterns
        step('0, '1, 1'b1);
        step('1, '0, 1'b1);
        step('1, '1, 1'b1);
        step('0, '0, 1'b1);
    endtask

    task automatic t_first_pair();
        do_reset(1'b1);
        step(2'b11, 2'b01, 1'b0);
        check("R8 first edge early", u0_early, '0);
        check("R8 first edge late", u0_late, '0);
        step(2'b00, 2'b10, 1'b0);
        check("R8 first pair early", u0_early, 2'b11);
        check("R8 first pair late", u0_late, 2'b01);
    endtask

    task automatic t_ce_gap();
        step(2'b01, 2'b10, 1'b1);
        step(2'b10, 2'b01, 1'b1);
        @(negedge clk_lead); #1;
        ser = 2'b11;
        ce  = 1'b0;
        @(posedge clk_lead); #1;
        check("R6 hold early", u0_early, pp_a);
        check("R6 hold late", u0_late, pp_b);
        check("R6 hold bypass early", u1_early, last_a);
        ser = 2'b11;
        // step re-enables after the frozen trail edge
        step(2'b00, 2'b00, 1'b0);
        check("R6 skipped early", u0_early, 2'b10);
        check("R6 skipped late", u0_late, 2'b01);
        check("R6 skipped bypass late", u1_late, 2'b01);
        step(2'b01, 2'b01, 1'b0);
        check("R6 resume early", u0_early, 2'b00);
        check("R6 resume late", u0_late, 2'b00);
        last_a = 2'b01; last_b = 2'b01;
    endtask

    task automatic t_lanes();
        step(2'b01, 2'b10, 1'b1);
        step(2'b10, 2'b01, 1'b1);
        check("R7 lane0 early", {1'b0, u0_early[0]}, 2'b01);
        check("R7 lane1 early", {1'b0, u0_early[1]}, 2'b00);
        check("R7 lane0 late", {1'b0, u0_late[0]}, 2'b00);
        check("R7 lane1 late", {1'b0, u0_late[1]}, 2'b01);
    endtask

    task automatic t_reset_over_ce();
        step(2'b11, 2'b11, 1'b1);
        step(2'b11, 2'b11, 1'b1);
        do_reset(1'b0);
        step(2'b10, 2'b11, 1'b1);
        step(2'b01, 2'b00, 1'b1);
    endtask

    initial begin
        do_reset(1'b1);
        t_stream();
        t_first_pair();
        t_ce_gap();
        t_lanes();
        t_reset_over_ce();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule